// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

A 32-bit count-down timer that raises an interrupt request with a programmable vector when its count runs out. The count steps down once per divided tick. A three-bit divide code sets the tick rate to any power of two from 1 to 128 clock cycles. The timer runs in one of two modes. In one-shot mode it stops at zero. In periodic mode it reloads from the start value and keeps counting.

Software controls the timer through a small register port, selected by a 2-bit address:

| Select | Register | Access |
|---|---|---|
| 0 | Start value | read/write |
| 1 | Live count | read-only |
| 2 | Divide setting | read/write |
| 3 | Control entry (vector, mask flag, periodic flag) | read/write |

On expiry the block produces a one-cycle request pulse and presents the entry's vector beside it. The pulse is suppressed while the entry is masked. Priority handling of the request happens downstream.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset, all of the following hold:
  - the start value and the live count read 0;
  - the divide setting reads 0, which means divide by 2;
  - the control entry reads 0x0001_0000 (masked, one-shot, vector 0);
  - `irq_pulse` is low.
- R2: The divide setting keeps only write bits 0, 1 and 3 and reads the other bits back as 0. The code is {bit3, bit1, bit0}. One tick lasts 2^((code+1) mod 8) clock cycles, so code 7 gives 1 cycle and codes 0 to 6 give 2 to 128 cycles.
- R3: Writing the start value (select 0) loads it into the live count and restarts the divider. The first decrement follows one full tick period after the write edge.
- R4: In one-shot mode with start value N > 0 and tick period D, all of the following hold:
  - the live count reads N - floor(k/D) k cycles after the load;
  - the count reaches 0 at k = N·D and then stays at 0;
  - `irq_pulse` is high for exactly the one cycle in which the count first reads 0.
- R5: In periodic mode, the tick after the count reads 0 reloads the start value. Expiries then repeat every (N+1)·D cycles, each with a one-cycle pulse.
- R6: The control entry has the mask flag at bit 16. While that flag is set, no pulse is produced, and counting is unaffected.
- R7: Writes to the live count (select 1) are ignored. Counting continues as if no write had occurred.
- R8: A start value of 0 leaves the count at 0 in both modes and never produces a pulse.
- R9: Writing the control entry does not restart the countdown. A new vector or mask value is used at the next expiry.
- R10: The control entry reads back the vector in bits 7:0, the mask flag in bit 16 and the periodic flag in bit 17, with all other bits 0. `irq_vector` shows the vector that was latched at the last expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 start, 1 live count (ignored), 2 divide, 3 entry |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | 32 | Combinational read data |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector latched at the last expiry |

## Verification
A wrong prescaler phase or divide decode moves every decrement. It shows up as a live-count miscompare at the first tick, one tick period after the load. A wrong reload or wrong stop condition appears within one period after zero: the count leaves 0 when it should hold, or holds when it should reload. A mask or vector taken from the wrong moment shows as a pulse or vector mismatch at the very expiry where it is used. Sweeping all eight divide codes in both modes aligns every such fault with a cycle the bench predicts exactly.

// File: rtl/lit_pkg.sv
// Package for the local interrupt timer.
// Contents: register select codes, control entry layout and the divide decode.
// Assumes: counter width is at least PER_POS+1 bits, so the entry fields fit the data word.
package lit_pkg;
    localparam int VEC_W    = 8;
    localparam int SEL_W    = 2;
    localparam int SHIFT_W  = 3;
    localparam int MASK_POS = 16;
    localparam int PER_POS  = 17;
    localparam logic [3:0] DIV_KEEP = 4'b1011;

    typedef enum logic [SEL_W-1:0] {
        SEL_START = 2'd0,
        SEL_LIVE  = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_ENTRY = 2'd3
    } sel_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } entry_t;

    // Convert the kept divide bits into a shift amount (code+1, wrapping at 8)
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] d);
        logic [SHIFT_W-1:0] code;
        code = {d[3], d[1:0]};
        return code + 1'b1;
    endfunction
endpackage

// File: rtl/lit_regs.sv
// Register file and read multiplexer of the local interrupt timer.
// Holds the start value, the divide setting and the control entry.
// Writes to the live-count select are dropped.
// Assumes: CNT_W > lit_pkg::PER_POS.
module lit_regs #(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [1:0]            rd_sel,
    input  logic [CNT_W-1:0]      live_count,
    output logic [CNT_W-1:0]      start_val,
    output logic [3:0]            div_q,
    output lit_pkg::entry_t       entry,
    output logic                  load,
    output logic [CNT_W-1:0]      rd_data
);
    import lit_pkg::*;

    // Load strobe for the counter and the prescaler
    assign load = wr_en && (sel_e'(wr_sel) == SEL_START);

    // Register update on writes; the live-count select has no storage here
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= '0;
            div_q     <= '0;
            entry     <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
        end else if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_START: start_val <= wr_data;
                SEL_DIV:   div_q     <= wr_data[3:0] & DIV_KEEP;
                SEL_ENTRY: entry     <= '{periodic: wr_data[PER_POS],
                                          masked:   wr_data[MASK_POS],
                                          vector:   wr_data[VEC_W-1:0]};
                SEL_LIVE:  ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        case (sel_e'(rd_sel))
            SEL_START: rd_data = start_val;
            SEL_LIVE:  rd_data = live_count;
            SEL_DIV:   rd_data[3:0] = div_q;
            SEL_ENTRY: begin
                rd_data[VEC_W-1:0] = entry.vector;
                rd_data[MASK_POS]  = entry.masked;
                rd_data[PER_POS]   = entry.periodic;
            end
        endcase
    end
endmodule

// File: rtl/lit_prescale.sv
// Power-of-two clock divider.
// Produces a one-cycle tick every 2^shift cycles. It restarts its phase on a load,
// so the first tick comes one full period after the load edge.
// Assumes: the shift changes only while the timer is idle, or an uneven first period is accepted.
module lit_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;

    // Mask of the low bits that must all be one for a tick
    assign lim  = ~({PRE_W{1'b1}} << shift);
    assign tick = (pre & lim) == lim;

    // Free-running phase counter, cleared on load
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre <= '0;
        else                   pre <= pre + 1'b1;
    end
endmodule

// File: rtl/lit_counter.sv
// Count-down core.
// Steps down once per tick. At zero it holds in one-shot mode, or reloads the start
// value on the next tick in periodic mode. A load takes priority over a tick.
// hit flags the step from 1 to 0.
// Assumes: tick is a single-cycle strobe.
module lit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    // Expiry: a tick that takes the count from 1 to 0
    assign hit = tick && !load && (count == CNT_W'(1));

    // Count state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            if (count != '0)   count <= count - 1'b1;
            else if (periodic) count <= reload_val;
        end
    end
endmodule

// File: rtl/loc_irq_timer.sv
// Top of the local interrupt timer.
// Joins the register file, the divider and the count core. It registers the request
// pulse and its vector, and uses the entry values current at the expiry edge.
// Assumes: the bus writes at most one register per cycle.
module loc_irq_timer #(
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic [1:0]                rd_sel,
    output logic [CNT_W-1:0]          rd_data,
    output logic                      irq_pulse,
    output logic [lit_pkg::VEC_W-1:0] irq_vector
);
    import lit_pkg::*;

    logic [CNT_W-1:0]   start_val;
    logic [CNT_W-1:0]   live_count;
    logic [3:0]         div_q;
    entry_t             entry;
    logic               load;
    logic               tick;
    logic               hit;
    logic [SHIFT_W-1:0] shift;

    assign shift = div_to_shift(div_q);

    lit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .live_count(live_count), .start_val(start_val), .div_q(div_q),
        .entry(entry), .load(load), .rd_data(rd_data)
    );

    lit_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(load), .shift(shift), .tick(tick)
    );

    lit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(start_val_next(wr_data)),
        .reload_val(start_val), .tick(tick), .periodic(entry.periodic),
        .count(live_count), .hit(hit)
    );

    // The load value is the write data itself, since the start register updates on the same edge
    function automatic logic [CNT_W-1:0] start_val_next(input logic [CNT_W-1:0] d);
        return d;
    endfunction

    // Request output: a pulse unless masked, with the vector latched at each expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse <= hit && !entry.masked;
            if (hit) irq_vector <= entry.vector;
        end
    end
endmodule

// File: rtl/loc_irq_timer_chk.sv
// Property checker for the local interrupt timer, attached to the top by bind.
module loc_irq_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             irq_pulse,
    input logic [CNT_W-1:0] live_count,
    input logic             masked,
    input logic             periodic
);
    import lit_pkg::*;

    logic start_wr;
    assign start_wr = wr_en && (wr_sel == SEL_START);

    // R6: a pulse only follows an unmasked entry
    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(masked));

    // R4: the request lasts one cycle
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R4: a pulse marks the step from 1 to 0
    assert_fire_from_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(live_count) == CNT_W'(1) && live_count == '0));

    // R4: in one-shot mode zero holds until a new start value is written
    assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && live_count == '0 && !start_wr) |=> live_count == '0);

    // R7: a nonzero count never rises without a start write
    assert_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_count != '0 && !start_wr) |=> live_count <= $past(live_count));
endmodule

bind loc_irq_timer loc_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .irq_pulse(irq_pulse),
    .live_count(live_count), .masked(entry.masked), .periodic(entry.periodic)
);

// File: tb/test_loc_irq_timer.sv
module test_loc_irq_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data;
    logic irq_pulse;
    logic [7:0] irq_vector;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    loc_irq_timer #(.CNT_W(CNT_W)) i_loc_irq_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic reg_write(input int sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input int sel, output logic [31:0] v);
        rd_sel = 2'(sel);
        #1;
        v = rd_data;
    endtask

    // Load a configuration, then compare count and request every cycle against the model
    task automatic sweep(input int code, input int n, input bit per, input bit msk,
                         input int vec, input int poke_k, input int poke_sel,
                         input logic [31:0] poke_data, input bit poke_entry, input string tag);
        int d;
        int cycles;
        logic [31:0] dv;
        logic [31:0] ent;
        logic [31:0] r;
        bit msk_e;
        logic [7:0] vec_e;
        d = 1 << ((code + 1) % 8);
        cycles = per ? (2*n + 2)*d + 2 : (n + 2)*d + 2;
        dv = 32'((((code >> 2) & 1) << 3) | (code & 3));
        reg_write(2, dv | 32'h0000_00F4);
        reg_read(2, r);
        check("R2 divide readback", r, dv);
        ent = (32'(per) << 17) | (32'(msk) << 16) | 32'(vec & 8'hFF);
        reg_write(3, ent);
        reg_read(3, r);
        check("R10 entry readback", r, ent);
        msk_e = poke_entry ? poke_data[16] : msk;
        vec_e = poke_entry ? poke_data[7:0] : 8'(vec);
        rd_sel = 2'd1;
        reg_write(0, 32'(n));
        for (int k = 0; k <= cycles; k++) begin
            int t;
            int exp_cur;
            bit fire;
            t = k / d;
            if (per) exp_cur = n - (t % (n + 1));
            else     exp_cur = (t >= n) ? 0 : n - t;
            fire = (n > 0) && (k > 0) && (k % d == 0) &&
                   (per ? (t % (n + 1) == n) : (t == n));
            check(k == 0 ? "R3 load" : tag, rd_data, 32'(exp_cur));
            check(tag, 32'(irq_pulse), 32'(fire && !msk_e));
            if (fire && !msk_e)
                check(poke_entry ? "R9 vector" : "R10 vector", 32'(irq_vector), 32'(vec_e));
            if (k == poke_k) begin
                wr_en = 1'b1; wr_sel = 2'(poke_sel); wr_data = poke_data;
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_read(0, r); check("R1 start", r, 32'h0);
        reg_read(1, r); check("R1 live", r, 32'h0);
        reg_read(2, r); check("R1 divide", r, 32'h0);
        reg_read(3, r); check("R1 entry", r, 32'h0001_0000);
        check("R1 irq", 32'(irq_pulse), 32'h0);
        // R4 one-shot over every divide code
        for (int c = 0; c < 8; c++) sweep(c, 3, 1'b0, 1'b0, 8'h20 + c, -1, 0, 32'h0, 1'b0, "R4");
        // R5 periodic over every divide code
        for (int c = 0; c < 8; c++) sweep(c, 2, 1'b1, 1'b0, 8'h60 + c, -1, 0, 32'h0, 1'b0, "R5");
        sweep(7, 1, 1'b1, 1'b0, 8'h71, -1, 0, 32'h0, 1'b0, "R5");
        // R8 zero start value in both modes
        sweep(7, 0, 1'b1, 1'b0, 8'h44, -1, 0, 32'h0, 1'b0, "R8");
        sweep(0, 0, 1'b0, 1'b0, 8'h45, -1, 0, 32'h0, 1'b0, "R8");
        // R6 masked entries
        sweep(7, 4, 1'b0, 1'b1, 8'h55, -1, 0, 32'h0, 1'b0, "R6");
        sweep(2, 2, 1'b1, 1'b1, 8'h56, -1, 0, 32'h0, 1'b0, "R6");
        // R7 write to live count is ignored
        sweep(7, 10, 1'b0, 1'b0, 8'h31, 2, 1, 32'h0000_0FFF, 1'b0, "R7");
        // R9 entry rewrite mid-count: unmask and new vector, no restart
        sweep(1, 5, 1'b0, 1'b1, 8'h12, 3, 3, 32'h0000_0099, 1'b1, "R9");
        finish_run();
    end
endmodule